// File: doc/BRIEF.md
# Power-Mode and Clock-Output Controller

This block sequences the low-power states of a small microcontroller and drives its clock-output pin. In run mode it passes a chosen divided clock (fc, f8 or f32) to the pin and keeps the processor, watchdog and peripheral clock enables asserted. A WAIT strobe from the core moves it to a light sleep in which only the bus and watchdog clocks halt. A configuration write that sets the all-clock-stop bit moves it to a deep sleep in which every oscillator and derived clock is halted.

Either sleep ends with a hardware reset or with an interrupt request whose enable bit was already set at the moment of entry. An interrupt wake returns the block to run mode in one cycle and raises a one-cycle wake pulse, which tells the core to vector to the interrupt routine. Oscillators, the core and the peripherals are modelled only as level inputs and enable outputs. Configuration is written through one strobe that loads all fields at once. The current field values are read back on dedicated outputs.

Top module: `pwrclk_ctrl`

## Requirements
- R1: After a synchronous reset: all three clock enables and osc_run are 1, clkout is 0, wake is 0, cksel_q is 00, pstop_q is 0, allstop_q is 0 and divsel_q is 1.
- R2: In run mode, clkout equals the selected source sampled at the previous clock edge. The cksel_q encoding is 00 = fc, 01 = f8, 10 = f32, and 11 = fc.
- R3: A write in run mode with wr_allstop = 1 enters stop mode at the next edge. In stop mode cpu_clk_en, wdt_clk_en, per_clk_en and osc_run are all 0, and allstop_q is 1.
- R4: At the write that enters stop mode, divsel_q becomes 1 if low_speed is 0 and keeps its previous value if low_speed is 1. Any other run-mode write loads divsel_q from wr_divsel.
- R5: A wait_stb in run mode enters wait mode at the next edge. In wait mode cpu_clk_en and wdt_clk_en are 0, osc_run is 1, and per_clk_en equals the inverse of pstop_q.
- R6: In wait or stop mode, an irq_req bit whose irq_en bit was 1 in the entry cycle returns the block to run mode at the next edge. In that cycle wake is 1 for exactly one cycle and allstop_q is 0. Enable bits set only after entry cause no wake.
- R7: In wait mode, clkout keeps following the source when fc (00 or 11) is selected or when pstop_q is 0. With f8 or f32 selected and pstop_q = 1, clkout holds its level from the entry cycle.
- R8: In stop mode, clkout is driven to 1 when fc (00 or 11) is selected and holds its pre-stop level when f8 or f32 is selected.
- R9: Configuration writes, including a write of wr_allstop = 1, have no effect while in wait or stop mode.
- R10: When a run-mode write with wr_allstop = 1 and a wait_stb arrive in the same cycle, the block enters stop mode.
- R11: A reset asserted during wait or stop mode returns the block to run mode with divsel_q = 1 and wake = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Configuration write strobe, loads all fields |
| wr_cksel | input | 2 | Clock-output source select to write |
| wr_pstop | input | 1 | Peripheral-clock-stop-in-wait value to write |
| wr_allstop | input | 1 | All-clock-stop request to write |
| wr_divsel | input | 1 | Main-clock divide select to write |
| wait_stb | input | 1 | WAIT instruction strobe from the core |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Interrupt enable bits |
| low_speed | input | 1 | 1 when the core runs in low-speed or low-power mode |
| tap_f8 | input | 1 | Level of the f8 divided clock |
| tap_f32 | input | 1 | Level of the f32 divided clock |
| tap_fc | input | 1 | Level of the fc sub clock |
| cpu_clk_en | output | 1 | Bus/CPU clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillators running |
| clkout | output | 1 | Clock-output pin level |
| wake | output | 1 | One-cycle interrupt wake event |
| cksel_q | output | 2 | Current clock-output select |
| pstop_q | output | 1 | Current peripheral-stop-in-wait bit |
| allstop_q | output | 1 | Current all-clock-stop bit |
| divsel_q | output | 1 | Current main-clock divide select |

## Verification
Two events can land in the same cycle and must be resolved. A stop-entry write can coincide with a WAIT strobe, and stop must win. A configuration write can coincide with a wait or stop state, and the write must be dropped. Directed cases force each collision, and random traffic repeats them many times. A bench model that applies the stated priorities predicts the mode-dependent enables, the clkout level and the register readback every cycle.

// File: rtl/pwrclk_pkg.sv
package pwrclk_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_WAIT = 2'd1,
        PM_STOP = 2'd2
    } pmode_e;

    typedef struct packed {
        logic [1:0] cksel;
        logic       pstop;
        logic       allstop;
        logic       divsel;
    } ctl_regs_t;

    typedef struct packed {
        logic fc;
        logic f8;
        logic f32;
    } clk_taps_t;

    localparam ctl_regs_t CTL_RESET = '{cksel: 2'b00, pstop: 1'b0, allstop: 1'b0, divsel: 1'b1};

    // 01 -> f8, 10 -> f32, 00 and 11 -> fc
    function automatic logic pick_src(input logic [1:0] sel, input clk_taps_t t);
        case (sel)
            2'b01:   return t.f8;
            2'b10:   return t.f32;
            default: return t.fc;
        endcase
    endfunction

    function automatic logic sel_is_fc(input logic [1:0] sel);
        return (sel == 2'b00) || (sel == 2'b11);
    endfunction

endpackage

// File: rtl/pwrclk_mode_fsm.sv
module pwrclk_mode_fsm
    import pwrclk_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_allstop,
    input  logic               wait_stb,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    output pmode_e             mode,
    output logic               enter_stop,
    output logic               wake_now,
    output logic               wake_q
);

    logic [NUM_IRQ-1:0] en_snap;
    logic               enter_wait;

    // stop request has priority over a same-cycle WAIT strobe
    assign enter_stop = (mode == PM_RUN) && wr_en && wr_allstop;
    assign enter_wait = (mode == PM_RUN) && wait_stb && !enter_stop;
    assign wake_now   = (mode != PM_RUN) && (|(irq_req & en_snap));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= PM_RUN;
            en_snap <= '0;
            wake_q  <= 1'b0;
        end else begin
            wake_q <= wake_now;
            if (enter_stop) begin
                mode    <= PM_STOP;
                en_snap <= irq_en;
            end else if (enter_wait) begin
                mode    <= PM_WAIT;
                en_snap <= irq_en;
            end else if (wake_now) begin
                mode <= PM_RUN;
            end
        end
    end

endmodule

// File: rtl/pwrclk_ctl_regs.sv
module pwrclk_ctl_regs
    import pwrclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pmode_e     mode,
    input  logic       wr_en,
    input  logic [1:0] wr_cksel,
    input  logic       wr_pstop,
    input  logic       wr_divsel,
    input  logic       low_speed,
    input  logic       enter_stop,
    input  logic       wake_now,
    output ctl_regs_t  regs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= CTL_RESET;
        end else if (mode == PM_RUN) begin
            if (wr_en) begin
                regs.cksel <= wr_cksel;
                regs.pstop <= wr_pstop;
                if (enter_stop) begin
                    regs.allstop <= 1'b1;
                    regs.divsel  <= low_speed ? regs.divsel : 1'b1;
                end else begin
                    regs.divsel <= wr_divsel;
                end
            end
        end else if (wake_now) begin
            regs.allstop <= 1'b0;
        end
    end

endmodule

// File: rtl/pwrclk_out_drv.sv
module pwrclk_out_drv
    import pwrclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pmode_e     mode,
    input  logic [1:0] cksel,
    input  logic       pstop,
    input  clk_taps_t  taps,
    output logic       clkout
);

    logic src;
    logic nxt;

    assign src = pick_src(cksel, taps);

    always_comb begin
        case (mode)
            PM_WAIT: nxt = (sel_is_fc(cksel) || !pstop) ? src : clkout;
            PM_STOP: nxt = sel_is_fc(cksel) ? 1'b1 : clkout;
            default: nxt = src;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) clkout <= 1'b0;
        else     clkout <= nxt;
    end

endmodule

// File: rtl/pwrclk_ctrl.sv
module pwrclk_ctrl
    import pwrclk_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_cksel,
    input  logic               wr_pstop,
    input  logic               wr_allstop,
    input  logic               wr_divsel,
    input  logic               wait_stb,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               low_speed,
    input  logic               tap_f8,
    input  logic               tap_f32,
    input  logic               tap_fc,
    output logic               cpu_clk_en,
    output logic               wdt_clk_en,
    output logic               per_clk_en,
    output logic               osc_run,
    output logic               clkout,
    output logic               wake,
    output logic [1:0]         cksel_q,
    output logic               pstop_q,
    output logic               allstop_q,
    output logic               divsel_q
);

    pmode_e    mode;
    logic      enter_stop;
    logic      wake_now;
    ctl_regs_t regs;
    clk_taps_t taps;

    assign taps = '{fc: tap_fc, f8: tap_f8, f32: tap_f32};

    pwrclk_mode_fsm #(.NUM_IRQ(NUM_IRQ)) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_allstop (wr_allstop),
        .wait_stb   (wait_stb),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .mode       (mode),
        .enter_stop (enter_stop),
        .wake_now   (wake_now),
        .wake_q     (wake)
    );

    pwrclk_ctl_regs regs_i (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .wr_en      (wr_en),
        .wr_cksel   (wr_cksel),
        .wr_pstop   (wr_pstop),
        .wr_divsel  (wr_divsel),
        .low_speed  (low_speed),
        .enter_stop (enter_stop),
        .wake_now   (wake_now),
        .regs       (regs)
    );

    pwrclk_out_drv out_i (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .cksel  (regs.cksel),
        .pstop  (regs.pstop),
        .taps   (taps),
        .clkout (clkout)
    );

    assign cpu_clk_en = (mode == PM_RUN);
    assign wdt_clk_en = (mode == PM_RUN);
    assign per_clk_en = (mode == PM_RUN) || ((mode == PM_WAIT) && !regs.pstop);
    assign osc_run    = (mode != PM_STOP);

    assign cksel_q   = regs.cksel;
    assign pstop_q   = regs.pstop;
    assign allstop_q = regs.allstop;
    assign divsel_q  = regs.divsel;

endmodule

// File: rtl/pwrclk_ctrl_chk.sv
module pwrclk_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_allstop,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_run,
    input logic       clkout,
    input logic       wake,
    input logic [1:0] cksel_q,
    input logic       pstop_q,
    input logic       allstop_q
);

    // R3
    stop_gates_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_allstop && cpu_clk_en) |=> (!osc_run && !per_clk_en && allstop_q));

    // R5
    wait_per_chk: assert property (@(posedge clk) disable iff (rst)
        (osc_run && !cpu_clk_en) |-> (per_clk_en == !pstop_q));

    // R6
    wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);

    // R6
    wake_run_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> (cpu_clk_en && !allstop_q));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (osc_run && !cpu_clk_en && pstop_q && (cksel_q == 2'b01 || cksel_q == 2'b10))
        |=> $stable(clkout));

    // R8
    stop_fc_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!osc_run && (cksel_q == 2'b00 || cksel_q == 2'b11)) |=> clkout);

    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!osc_run && (cksel_q == 2'b01 || cksel_q == 2'b10)) |=> $stable(clkout));

    // R9
    sleep_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_clk_en && wr_en) |=> ($stable(cksel_q) && $stable(pstop_q)));

endmodule

bind pwrclk_ctrl pwrclk_ctrl_chk chk_i (.*);

// File: tb/pwrclk_ctrl_tb_top.sv
module pwrclk_ctrl_tb_top;

    localparam int NI = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 0, wr_pstop = 0, wr_allstop = 0, wr_divsel = 0;
    logic [1:0]    wr_cksel = 0;
    logic          wait_stb = 0, low_speed = 0;
    logic [NI-1:0] irq_req = '0, irq_en = '0;
    logic          tap_f8 = 0, tap_f32 = 0, tap_fc = 0;
    logic          cpu_clk_en, wdt_clk_en, per_clk_en, osc_run, clkout, wake;
    logic [1:0]    cksel_q;
    logic          pstop_q, allstop_q, divsel_q;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    // bench model state: 0 run, 1 wait, 2 stop
    int            m_mode;
    logic [1:0]    m_cksel;
    logic          m_pstop, m_allstop, m_divsel, m_clk, m_wake;
    logic [NI-1:0] m_snap;

    always #2.5 clk = ~clk;

    pwrclk_ctrl #(.NUM_IRQ(NI)) dut_i (.*);

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_err++;
                $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic src_of(input logic [1:0] s);
        case (s)
            2'b01:   return tap_f8;
            2'b10:   return tap_f32;
            default: return tap_fc;
        endcase
    endfunction

    function automatic logic is_fc(input logic [1:0] s);
        return s == 2'b00 || s == 2'b11;
    endfunction

    task automatic tick();
        int            nm = m_mode;
        logic [1:0]    ncks = m_cksel;
        logic          nps = m_pstop, nas = m_allstop, nds = m_divsel, nclk = m_clk, nwk = 1'b0;
        logic [NI-1:0] nsnap = m_snap;
        string         clk_req;
        if (rst) begin
            nm = 0; ncks = 0; nps = 0; nas = 0; nds = 1; nclk = 0; nsnap = '0;
            clk_req = "R11";
        end else begin
            case (m_mode)
                0: begin
                    clk_req = "R2";
                    nclk = src_of(m_cksel);
                    if (wr_en) begin
                        ncks = wr_cksel; nps = wr_pstop;
                        if (wr_allstop) begin
                            nm = 2; nas = 1; nsnap = irq_en;
                            nds = low_speed ? m_divsel : 1'b1;
                        end else nds = wr_divsel;
                    end
                    if (!(wr_en && wr_allstop) && wait_stb) begin
                        nm = 1; nsnap = irq_en;
                    end
                end
                1: begin
                    clk_req = "R7";
                    nclk = (is_fc(m_cksel) || !m_pstop) ? src_of(m_cksel) : m_clk;
                    if (|(irq_req & m_snap)) begin nm = 0; nwk = 1; end
                end
                default: begin
                    clk_req = "R8";
                    nclk = is_fc(m_cksel) ? 1'b1 : m_clk;
                    if (|(irq_req & m_snap)) begin nm = 0; nwk = 1; nas = 0; end
                end
            endcase
        end
        @(posedge clk);
        #1;
        m_mode = nm; m_cksel = ncks; m_pstop = nps; m_allstop = nas;
        m_divsel = nds; m_clk = nclk; m_wake = nwk; m_snap = nsnap;
        begin
            string er = (m_mode == 2) ? "R3" : (m_mode == 1) ? "R5" : "R1";
            chk(er, {3'b0, cpu_clk_en}, {3'b0, m_mode == 0});
            chk(er, {3'b0, wdt_clk_en}, {3'b0, m_mode == 0});
            chk(er, {3'b0, per_clk_en}, {3'b0, m_mode == 0 || (m_mode == 1 && !m_pstop)});
            chk(er, {3'b0, osc_run}, {3'b0, m_mode != 2});
        end
        chk(clk_req, {3'b0, clkout}, {3'b0, m_clk});
        chk("R6", {3'b0, wake}, {3'b0, m_wake});
        chk("R6", {3'b0, allstop_q}, {3'b0, m_allstop});
        chk("R4", {3'b0, divsel_q}, {3'b0, m_divsel});
        chk("R9", {2'b0, cksel_q}, {2'b0, m_cksel});
        chk("R9", {3'b0, pstop_q}, {3'b0, m_pstop});
    endtask

    task automatic idle();
        wr_en = 0; wr_allstop = 0; wait_stb = 0; irq_req = '0;
    endtask

    task automatic wr(input logic [1:0] cs, input logic ps, input logic as, input logic ds);
        wr_en = 1; wr_cksel = cs; wr_pstop = ps; wr_allstop = as; wr_divsel = ds;
        tick();
        wr_en = 0; wr_allstop = 0;
    endtask

    task automatic rand_taps();
        tap_f8 = 1'($urandom); tap_f32 = 1'($urandom); tap_fc = 1'($urandom);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        m_mode = 0; m_cksel = 0; m_pstop = 0; m_allstop = 0; m_divsel = 1;
        m_clk = 0; m_wake = 0; m_snap = '0;
        rst = 1; tick(); tick();
        rst = 0;
        // R1 reset state
        chk("R1", {3'b0, cpu_clk_en & wdt_clk_en & per_clk_en & osc_run}, 4'h1);
        chk("R1", {3'b0, clkout | wake | allstop_q | pstop_q}, 4'h0);
        chk("R1", {2'b0, cksel_q}, 4'h0);
        chk("R1", {3'b0, divsel_q}, 4'h1);

        // R2 each select value with toggling taps
        for (int s = 0; s < 4; s++) begin
            wr(2'(s), 0, 0, 0);
            for (int k = 0; k < 4; k++) begin rand_taps(); tick(); end
        end

        // R4 stop from high speed forces divsel; R8 fc drives high
        low_speed = 0; tap_fc = 0;
        wr(2'b00, 0, 0, 0);
        wr(2'b00, 0, 1, 0);
        chk("R4", {3'b0, divsel_q}, 4'h1);
        tick(); tick();
        chk("R8", {3'b0, clkout}, 4'h1);
        // R6 enable set only after entry: no wake
        irq_en = 8'h01; irq_req = 8'h01; tick(); tick();
        chk("R6", {3'b0, osc_run}, 4'h0);
        // R11 reset from stop
        rst = 1; tick(); rst = 0; idle();
        chk("R11", {3'b0, cpu_clk_en & divsel_q & ~wake}, 4'h1);

        // R4 stop from low speed keeps divsel 0; R8 hold with f8
        low_speed = 1; irq_en = 8'h10;
        wr(2'b01, 0, 0, 0);
        tap_f8 = 1; tick();
        wr(2'b01, 0, 1, 1);
        chk("R4", {3'b0, divsel_q}, 4'h0);
        for (int k = 0; k < 4; k++) begin tap_f8 = ~tap_f8; tick(); end
        irq_req = 8'h10; tick(); idle();
        chk("R6", {3'b0, wake & cpu_clk_en}, 4'h1);
        tick();
        chk("R6", {3'b0, wake}, 4'h0);

        // R5/R7 wait with pstop and f32, R9 stop write ignored in wait
        low_speed = 0; irq_en = 8'h04;
        wr(2'b10, 1, 0, 1);
        tap_f32 = 1; tick();
        wait_stb = 1; tick(); wait_stb = 0;
        for (int k = 0; k < 3; k++) begin tap_f32 = ~tap_f32; tick(); end
        wr(2'b00, 0, 1, 0);
        chk("R9", {3'b0, osc_run & ~allstop_q}, 4'h1);
        irq_req = 8'h04; tick(); idle(); tick();

        // R10 same-cycle WAIT strobe and stop write
        irq_en = 8'h02;
        wait_stb = 1; wr(2'b00, 0, 1, 1); wait_stb = 0;
        chk("R10", {3'b0, osc_run}, 4'h0);
        irq_req = 8'h02; tick(); idle(); tick();

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            rand_taps();
            rst        = ($urandom % 400) == 0;
            wr_en      = ($urandom % 12) == 0;
            wr_cksel   = 2'($urandom);
            wr_pstop   = 1'($urandom);
            wr_allstop = ($urandom % 3) == 0;
            wr_divsel  = 1'($urandom);
            wait_stb   = ($urandom % 15) == 0;
            low_speed  = 1'($urandom);
            irq_en     = NI'($urandom);
            irq_req    = (($urandom % 10) == 0) ? NI'($urandom) : '0;
            tick();
        end
        rst = 0; idle(); tick();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule